// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block turns a single bus request from an 8-bit processor core into the pin-level timing of one machine cycle. The core picks a cycle kind (instruction fetch, memory read, memory write, port read or port write) and supplies a 16-bit address and, for writes, a data byte. The sequencer drives the address and write-data outputs and the four active-low strobes: memory request, port request, read and write. It samples an active-low wait input, captures read data from the data-in bus and hands it back to the core together with a one-clock completion pulse.

The block runs from a clock at twice the T-state rate. A phase bit splits every T-state into a first half and a second half, so strobes can change on half-T-state boundaries while all logic stays synchronous to one edge. Fetch cycles also place a 7-bit refresh count on the low address bits in their last two T-states, with the memory strobe active and read inactive, for dynamic memory refresh. A request is taken only while the block is idle. One idle clock separates two machine cycles.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, and in the clock that follows every completed cycle, `req_ready` is 1, `rsp_done` is 0, `bus_dout_en` is 0 and all four strobes are high.
- R2: A fetch (`req_kind` = 0) with no wait lasts 4 T-states (8 clocks). `bus_mreq_n` and `bus_rd_n` are low from the second half of T1 to the end of T2.
- R3: During T3 and T4 of a fetch, `bus_addr` carries the refresh count on its low 7 bits and zeros above. `bus_mreq_n` is low in the second half of T3 and the first half of T4, while `bus_rd_n` stays high.
- R4: The refresh count is 0 after reset and rises by one, modulo 128, at the end of each fetch.
- R5: A memory read (kind 1) or memory write (kind 2) with no wait lasts 3 T-states (6 clocks). `bus_mreq_n` is low, with `bus_rd_n` (read) or `bus_wr_n` (write), from the second half of T1 to the end of the first half of T3. The strobes go high in the last half T-state, before the address or the data may change.
- R6: A port read (kind 3) or port write (kind 4) lasts 4 T-states (T1, T2, one automatic wait state, T3). `bus_iorq_n` is low with `bus_rd_n` or `bus_wr_n` from the start of T2 to the end of the first half of T3. `bus_mreq_n` stays high.
- R7: `bus_wait_n` is sampled at the end of T2 for fetch and memory cycles, and at the end of each inserted wait state for port cycles. Each low sample adds one whole T-state, during which strobes and address are held.
- R8: `rsp_done` is high for exactly one clock, the second half of the final T-state. For reads, `rsp_rdata` then holds `bus_din` as captured at the end of T2 (or of the last wait state) for fetches, and at the end of the first half of T3 otherwise.
- R9: Throughout a cycle the address is held, except for the refresh window of R3. For writes, `bus_dout_en` is 1 and `bus_dout` holds the request data for the whole cycle.
- R10: While a cycle is running, `req_ready` is 0 and `req_valid` with new fields has no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 port read, 4 port write |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block idle, request taken this clock |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Captured read data |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Data-out bus |
| bus_dout_en | output | 1 | Data-out drive enable |
| bus_din | input | 8 | Data-in bus |
| bus_mreq_n | output | 1 | Memory request strobe, active low |
| bus_iorq_n | output | 1 | Port request strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_wait_n | input | 1 | Wait request, active low |

## Verification
The bench builds the block with its default widths: a 16-bit address, an 8-bit data path and a 7-bit refresh count. The small refresh width lets a run of 130 fetches carry the count through its wrap from 127 to 0. The sweep crosses all five cycle kinds with zero to three wait samples and edge-case addresses, and checks strobes, address, data and completion on every half T-state against lengths computed arithmetically. The data-in bus holds the expected byte only in the capture slot, which pins down the sampling instant.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } cyc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_T1    = 3'd1,
    S_T2    = 3'd2,
    S_TAUTO = 3'd3,
    S_TWAIT = 3'd4,
    S_T3    = 3'd5,
    S_T4    = 3'd6
  } tstate_e;

endpackage

// File: rtl/bcs_tstate_fsm.sv
module bcs_tstate_fsm
  import bcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    is_fetch,
  input  logic    is_io,
  input  logic    wait_n,
  output tstate_e state_o,
  output logic    phase_o,
  output logic    smp_pass_o
);

  tstate_e st_q, st_d;
  logic    ph_q, ph_d;
  logic    adv_en;

  // Clock enable: the sequencer only moves when busy or starting
  assign adv_en = (st_q != S_IDLE) | start;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    if (st_q == S_IDLE) begin
      if (start) begin
        st_d = S_T1;
        ph_d = 1'b0;
      end
    end else if (!ph_q) begin
      ph_d = 1'b1;
    end else begin
      ph_d = 1'b0;
      case (st_q)
        S_T1:    st_d = S_T2;
        S_T2: begin
          if (is_io)       st_d = S_TAUTO;
          else if (wait_n) st_d = S_T3;
          else             st_d = S_TWAIT;
        end
        S_TAUTO,
        S_TWAIT: st_d = wait_n ? S_T3 : S_TWAIT;
        S_T3:    st_d = is_fetch ? S_T4 : S_IDLE;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      ph_q <= 1'b0;
    end else if (adv_en) begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  // Leaving a wait-sampling point towards T3 this clock
  assign smp_pass_o = ph_q & wait_n &
                      (((st_q == S_T2) & ~is_io) | (st_q == S_TAUTO) | (st_q == S_TWAIT));

  assign state_o = st_q;
  assign phase_o = ph_q;

endmodule

// File: rtl/bcs_rfsh_ctr.sv
module bcs_rfsh_ctr #(
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [RW-1:0] cnt_o
);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(RW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 7
) (
  input  tstate_e       state,
  input  logic          phase,
  input  cyc_kind_e     kind,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic [RW-1:0] rfsh,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o,
  output logic          mreq_n_o,
  output logic          iorq_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          done_o,
  output logic          cap_rd_o,
  output logic          rfsh_inc_o
);

  localparam int PAD_W = AW - RW;

  logic is_fetch, is_io, is_rd, is_wr;
  logic t1b, t3a, t3b, t4a, t4b, mid;
  logic mem_span, io_span, span, rf_span, rf_addr;

  always_comb begin
    is_fetch = (kind == K_FETCH);
    is_io    = (kind == K_IORD) | (kind == K_IOWR);
    is_rd    = (kind == K_FETCH) | (kind == K_MRD) | (kind == K_IORD);
    is_wr    = (kind == K_MWR) | (kind == K_IOWR);

    t1b = (state == S_T1) &  phase;
    t3a = (state == S_T3) & ~phase;
    t3b = (state == S_T3) &  phase;
    t4a = (state == S_T4) & ~phase;
    t4b = (state == S_T4) &  phase;
    mid = (state == S_T2) | (state == S_TWAIT) | (state == S_TAUTO);

    mem_span = is_fetch ? (t1b | mid) : (t1b | mid | t3a);
    io_span  = mid | t3a;
    span     = is_io ? io_span : mem_span;
    rf_span  = is_fetch & (t3b | t4a);
    rf_addr  = is_fetch & ((state == S_T3) | (state == S_T4));

    mreq_n_o = ~((~is_io & span) | rf_span);
    iorq_n_o = ~(is_io & span);
    rd_n_o   = ~(is_rd & span);
    wr_n_o   = ~(is_wr & span);

    addr_o    = rf_addr ? {{PAD_W{1'b0}}, rfsh} : addr_q;
    dout_o    = wdata_q;
    dout_en_o = is_wr & (state != S_IDLE);

    done_o     = is_fetch ? t4b : t3b;
    cap_rd_o   = is_rd & ~is_fetch & t3a;
    rfsh_inc_o = t4b & is_fetch;
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  input  logic [DW-1:0] bus_din,
  output logic          bus_mreq_n,
  output logic          bus_iorq_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  input  logic          bus_wait_n
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  tstate_e       state;
  logic          phase, smp_pass, accept, cap_rd, rfsh_inc, cap_en;
  cyc_kind_e     kind_q, kind_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [RW-1:0] rfsh;
  logic          is_fetch, is_io;

  always_comb begin
    req_ready = (state == S_IDLE);
    accept    = req_valid & req_ready;
    case (req_kind)
      3'd0:    kind_d = K_FETCH;
      3'd2:    kind_d = K_MWR;
      3'd3:    kind_d = K_IORD;
      3'd4:    kind_d = K_IOWR;
      default: kind_d = K_MRD;
    endcase
    is_fetch = (kind_q == K_FETCH);
    is_io    = (kind_q == K_IORD) | (kind_q == K_IOWR);
    cap_en   = (is_fetch & smp_pass) | cap_rd;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      kind_q  <= K_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= kind_d;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)  rdata_q <= '0;
    else if (cap_en)  rdata_q <= bus_din;
  end

  bcs_tstate_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start      (accept),
    .is_fetch   (is_fetch),
    .is_io      (is_io),
    .wait_n     (bus_wait_n),
    .state_o    (state),
    .phase_o    (phase),
    .smp_pass_o (smp_pass)
  );

  bcs_rfsh_ctr #(.RW(RW)) u_rfsh (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .inc   (rfsh_inc),
    .cnt_o (rfsh)
  );

  bcs_strobe_gen #(.AW(AW), .DW(DW), .RW(RW)) u_strb (
    .state      (state),
    .phase      (phase),
    .kind       (kind_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .rfsh       (rfsh),
    .addr_o     (bus_addr),
    .dout_o     (bus_dout),
    .dout_en_o  (bus_dout_en),
    .mreq_n_o   (bus_mreq_n),
    .iorq_n_o   (bus_iorq_n),
    .rd_n_o     (bus_rd_n),
    .wr_n_o     (bus_wr_n),
    .done_o     (rsp_done),
    .cap_rd_o   (cap_rd),
    .rfsh_inc_o (rfsh_inc)
  );

  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_dout,
  input logic          bus_dout_en,
  input logic          bus_mreq_n,
  input logic          bus_iorq_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_mreq_n && bus_iorq_n && bus_rd_n && bus_wr_n && !bus_dout_en && !rsp_done)); // R1

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R5

  AST_WR_REL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> rsp_done); // R5

  AST_SPACE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_mreq_n && !bus_iorq_n)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |=> ($stable(bus_addr) && $stable(bus_dout) && bus_dout_en)); // R9

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !rsp_done) |=> !req_ready); // R10

endmodule

bind bus_cycle_seq bcs_checker #(.AW(AW), .DW(DW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .bus_addr    (bus_addr),
  .bus_dout    (bus_dout),
  .bus_dout_en (bus_dout_en),
  .bus_mreq_n  (bus_mreq_n),
  .bus_iorq_n  (bus_iorq_n),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n)
);

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_dout_en;
  logic [7:0]  bus_din;
  logic        bus_mreq_n, bus_iorq_n, bus_rd_n, bus_wr_n;
  logic        bus_wait_n;

  int n_chk;
  int n_bad;
  int rc;
  bit finished;

  bus_cycle_seq i_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_wait_n(bus_wait_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_check();
    chk(req_ready === 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
    chk({bus_mreq_n, bus_iorq_n, bus_rd_n, bus_wr_n} === 4'hF, "R1 strobes",
        {28'd0, bus_mreq_n, bus_iorq_n, bus_rd_n, bus_wr_n}, 32'hF);
    chk(rsp_done === 1'b0 && bus_dout_en === 1'b0, "R1 done/dout_en",
        {30'd0, rsp_done, bus_dout_en}, 32'd0);
  endtask

  task automatic run_cycle(input int kind, input logic [15:0] a, input logic [7:0] wd,
                           input int nw, input logic [7:0] rdin, input string rtag);
    bit fe, io, rd, wr, span, rf, refr;
    int len, cap, smp;
    logic [3:0]  exp_s;
    logic [15:0] exp_a;
    string stag;
    fe  = (kind == 0);
    io  = (kind >= 3);
    rd  = (kind == 0 || kind == 1 || kind == 3);
    wr  = (kind == 2 || kind == 4);
    len = (kind == 1 || kind == 2) ? 6 + 2*nw : 8 + 2*nw;
    cap = fe ? 3 + 2*nw : len - 2;
    smp = io ? 5 : 3;
    stag = (nw > 0) ? "R7 strobes" : (fe ? "R2 strobes" : (io ? "R6 strobes" : "R5 strobes"));
    req_valid = 1'b1;
    req_kind  = kind[2:0];
    req_addr  = a;
    req_wdata = wd;
    bus_wait_n = 1'b1;
    bus_din   = ~rdin;
    @(posedge clk);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      bus_wait_n = !(k >= smp && k < smp + 2*nw);
      bus_din    = (k == cap) ? rdin : ~rdin;
      req_valid  = (k != len - 1);
      req_addr   = ~a;
      req_kind   = 3'((kind + 1) % 5);
      req_wdata  = ~wd;
      if (fe) begin
        span = (k >= 1 && k <= 3 + 2*nw);
        rf   = (k == 5 + 2*nw) || (k == 6 + 2*nw);
        refr = (k >= 4 + 2*nw);
      end else begin
        span = io ? (k >= 2 && k <= len - 2) : (k >= 1 && k <= len - 2);
        rf   = 1'b0;
        refr = 1'b0;
      end
      exp_s = {!((span && !io) || rf), !(span && io), !(span && rd), !(span && wr)};
      chk({bus_mreq_n, bus_iorq_n, bus_rd_n, bus_wr_n} === exp_s, stag,
          {28'd0, bus_mreq_n, bus_iorq_n, bus_rd_n, bus_wr_n}, {28'd0, exp_s});
      exp_a = refr ? {9'd0, rc[6:0]} : a;
      chk(bus_addr === exp_a, refr ? rtag : "R9 address", {16'd0, bus_addr}, {16'd0, exp_a});
      chk(rsp_done === (k == len - 1), "R8 done", {31'd0, rsp_done}, {31'd0, k == len - 1});
      chk(req_ready === 1'b0, "R10 ready busy", {31'd0, req_ready}, 32'd0);
      if (wr) chk(bus_dout_en === 1'b1 && bus_dout === wd, "R9 write data",
                  {23'd0, bus_dout_en, bus_dout}, {23'd1, wd});
      if (rd && k == len - 1) chk(rsp_rdata === rdin, "R8 read data",
                                  {24'd0, rsp_rdata}, {24'd0, rdin});
    end
    @(negedge clk);
    idle_check();
    if (fe) rc = (rc + 1) % 128;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rc = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_kind = 3'd0;
    req_addr = 16'h0;
    req_wdata = 8'h0;
    bus_din = 8'h0;
    bus_wait_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_check();

    for (int kind = 0; kind < 5; kind++) begin
      for (int nw = 0; nw < 4; nw++) begin
        for (int v = 0; v < 3; v++) begin
          logic [15:0] a;
          logic [7:0]  d;
          a = (v == 0) ? 16'h0000 : (v == 1) ? 16'hFFFF : 16'((kind * 16'h1357) ^ (nw * 16'h0A5A));
          d = 8'((kind * 37 + nw * 11 + v * 73) ^ 8'h5C);
          run_cycle(kind, a, d, nw, 8'(d + 8'h21), "R3 refresh addr");
        end
      end
    end

    // Refresh count wraps through 127 -> 0
    for (int i = 0; i < 130; i++) begin
      run_cycle(0, 16'(16'h8000 + i), 8'h00, i % 2, 8'(i), "R4 refresh count");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule